// File: doc/BRIEF.md
# Supply Fault Detector Logic

This block is the digital back end of a single supply monitor. An 8-bit code that represents the digitised supply level arrives every clock. The block compares it against a programmable undervoltage limit and a programmable overvoltage limit, and each limit has its own hysteresis. A fault-kind selector takes one of the two comparison results, or their OR, as the raw fault. A delay-type glitch filter then turns the raw fault into the final flag. The filter is clocked by a tick from a slow timebase of about 100 kHz, so one tick is about 10 µs.

Hysteresis is used only to leave a fault, never to enter one. An undervoltage fault is raised as soon as the level falls below its limit. It is released only once the level rises above the limit plus the hysteresis. The overvoltage side works as the mirror image. Software programs the limits, the hysteresis, the fault kind and the filter timeout through a small write-only register port.

Top module: `supply_fault_det`

## Requirements
- R1: After reset the undervoltage limit is 0x00, the overvoltage limit is 0xFF, both hysteresis values are 0, the fault kind is undervoltage and the filter timeout is zero ticks. `fault_o` is low.
- R2: When the undervoltage flag is clear and `level_i` is below the undervoltage limit, the flag sets.
- R3: A set undervoltage flag clears only when `level_i` is greater than the undervoltage limit plus the undervoltage hysteresis.
- R4: When the overvoltage flag is clear and `level_i` is above the overvoltage limit, the flag sets.
- R5: A set overvoltage flag clears only when `level_i` plus the overvoltage hysteresis is below the overvoltage limit. If the limit is smaller than the hysteresis, the flag never clears.
- R6: The register addresses are: 0 undervoltage limit, 1 undervoltage hysteresis, 2 overvoltage limit, 3 overvoltage hysteresis, 4 select. Only bits [4:0] of a hysteresis write are kept (0 to 31), and bits [7:5] are ignored.
- R7: Select bits [1:0] choose the fault kind. The value 0 gives undervoltage only, 1 gives overvoltage only, and 2 or 3 give the window kind, which is the OR of both flags.
- R8: Select bits [4:2] pick a filter timeout of 0, 1, 2, 3, 4, 6, 8 or 10 ticks for codes 0 to 7. The output takes the raw fault's value on the clock edge of the tick that makes the count of ticks, while input and output differ, reach the timeout.
- R9: A raw fault difference that lasts fewer ticks than the timeout never reaches `fault_o`. When the raw fault returns to match the output, the tick count restarts from zero.
- R10: With timeout code 0 the filter is transparent. `fault_o` reflects a change of `level_i` on the second clock edge after it, whatever `tick_i` does.
- R11: Writing a new limit while a flag is set is re-evaluated on the next comparison, using the new limit with its hysteresis.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One-clock pulse from the slow timebase |
| level_i | input | 8 | Digitised supply level |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_addr_i | input | 3 | Register address |
| cfg_wdata_i | input | 8 | Register write data |
| fault_o | output | 1 | Filtered fault flag |

## Verification
The assertions check the per-cycle rules on every clock:
- entry into each flag;
- holding each flag inside its hysteresis band;
- stored hysteresis keeping only the low five bits;
- filter output staying frozen without a tick or without a difference;
- tick count clearing when input and output agree;
- one-clock transparency at timeout zero.

The bench sweeps the level down and then up through all 256 codes for several limit and hysteresis settings and compares against an arithmetic model. Only the bench scenarios can show the following:
- the exact tick count for each of the eight timeouts;
- suppression of pulses shorter than the timeout;
- re-evaluation after a limit is rewritten while a flag is set;
- the effect of each fault-kind code.

// File: rtl/sfd_pkg.sv
package sfd_pkg;
    localparam int DW  = 8;
    localparam int HW  = 5;
    localparam int AW  = 3;
    localparam int TSW = 3;
    localparam int CW  = 4;

    localparam logic [AW-1:0] A_UV_THR = 3'd0;
    localparam logic [AW-1:0] A_UV_HYS = 3'd1;
    localparam logic [AW-1:0] A_OV_THR = 3'd2;
    localparam logic [AW-1:0] A_OV_HYS = 3'd3;
    localparam logic [AW-1:0] A_SEL    = 3'd4;

    typedef enum logic [1:0] {
        FT_UV   = 2'd0,
        FT_OV   = 2'd1,
        FT_WIN  = 2'd2,
        FT_WIN2 = 2'd3
    } ftype_e;

    typedef struct packed {
        logic [DW-1:0]  uv_thr;
        logic [HW-1:0]  uv_hyst;
        logic [DW-1:0]  ov_thr;
        logic [HW-1:0]  ov_hyst;
        ftype_e         ftype;
        logic [TSW-1:0] tsel;
    } cfg_t;

    function automatic logic [CW-1:0] tsel_ticks(input logic [TSW-1:0] s);
        case (s)
            3'd0:    return 4'd0;
            3'd1:    return 4'd1;
            3'd2:    return 4'd2;
            3'd3:    return 4'd3;
            3'd4:    return 4'd4;
            3'd5:    return 4'd6;
            3'd6:    return 4'd8;
            default: return 4'd10;
        endcase
    endfunction
endpackage

// File: rtl/sfd_regs.sv
module sfd_regs
    import sfd_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we_i,
    input  logic [AW-1:0] addr_i,
    input  logic [DW-1:0] wdata_i,
    output cfg_t          cfg_o
);
    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (we_i) begin
            case (addr_i)
                A_UV_THR: cfg_d.uv_thr  = wdata_i;
                A_UV_HYS: cfg_d.uv_hyst = wdata_i[HW-1:0];
                A_OV_THR: cfg_d.ov_thr  = wdata_i;
                A_OV_HYS: cfg_d.ov_hyst = wdata_i[HW-1:0];
                A_SEL: begin
                    cfg_d.ftype = ftype_e'(wdata_i[1:0]);
                    cfg_d.tsel  = wdata_i[2+TSW-1:2];
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q.uv_thr  <= '0;
            cfg_q.uv_hyst <= '0;
            cfg_q.ov_thr  <= '1;
            cfg_q.ov_hyst <= '0;
            cfg_q.ftype   <= FT_UV;
            cfg_q.tsel    <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign cfg_o = cfg_q;

    // R6: a hysteresis write keeps only the low bits of the data
    a_r6_hyst_mask: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && addr_i == A_UV_HYS) |=> cfg_o.uv_hyst == $past(wdata_i[HW-1:0]));
endmodule

// File: rtl/sfd_compare.sv
module sfd_compare
    import sfd_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] level_i,
    input  cfg_t          cfg_i,
    output logic          raw_o
);
    typedef struct packed {
        logic uv;
        logic ov;
    } flags_t;

    flags_t st_d, st_q;
    logic   uv_enter, uv_leave, ov_enter, ov_leave;

    always_comb begin
        uv_enter = level_i < cfg_i.uv_thr;
        uv_leave = {1'b0, level_i} > ({1'b0, cfg_i.uv_thr} + {{(DW+1-HW){1'b0}}, cfg_i.uv_hyst});
        ov_enter = level_i > cfg_i.ov_thr;
        ov_leave = ({1'b0, level_i} + {{(DW+1-HW){1'b0}}, cfg_i.ov_hyst}) < {1'b0, cfg_i.ov_thr};

        st_d = st_q;
        if (!st_q.uv)     st_d.uv = uv_enter;
        else if (uv_leave) st_d.uv = 1'b0;
        if (!st_q.ov)     st_d.ov = ov_enter;
        else if (ov_leave) st_d.ov = 1'b0;

        case (cfg_i.ftype)
            FT_UV:   raw_o = st_q.uv;
            FT_OV:   raw_o = st_q.ov;
            default: raw_o = st_q.uv | st_q.ov;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R2
    a_r2_uv_enter: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.uv && level_i < cfg_i.uv_thr) |=> st_q.uv);
    // R3
    a_r3_uv_band_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.uv && ({1'b0, level_i} <= ({1'b0, cfg_i.uv_thr} + 9'(cfg_i.uv_hyst)))) |=> st_q.uv);
    // R4
    a_r4_ov_enter: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.ov && level_i > cfg_i.ov_thr) |=> st_q.ov);
    // R5
    a_r5_ov_band_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ov && (({1'b0, level_i} + 9'(cfg_i.ov_hyst)) >= {1'b0, cfg_i.ov_thr})) |=> st_q.ov);
endmodule

// File: rtl/sfd_glitch.sv
module sfd_glitch
    import sfd_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick_i,
    input  logic          raw_i,
    input  logic [CW-1:0] limit_i,
    output logic          flt_o
);
    typedef struct packed {
        logic          out;
        logic [CW-1:0] cnt;
    } filt_t;

    filt_t st_d, st_q;
    logic [CW-1:0] cnt_inc;

    always_comb begin
        cnt_inc = st_q.cnt + 1'b1;
        st_d    = st_q;
        if (raw_i == st_q.out) begin
            st_d.cnt = '0;
        end else if (limit_i == '0) begin
            st_d.out = raw_i;
            st_d.cnt = '0;
        end else if (tick_i) begin
            if (cnt_inc >= limit_i) begin
                st_d.out = raw_i;
                st_d.cnt = '0;
            end else begin
                st_d.cnt = cnt_inc;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flt_o = st_q.out;

    // R8: no difference, no change
    a_r8_agree_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (raw_i == flt_o) |=> $stable(flt_o));
    // R8: with a nonzero timeout the output only moves on a tick
    a_r8_tick_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (limit_i != '0 && !tick_i) |=> $stable(flt_o));
    // R9: count restarts when input matches output
    a_r9_count_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (raw_i == flt_o) |=> st_q.cnt == '0);
    // R10: zero timeout copies the input one clock later
    a_r10_transparent: assert property (@(posedge clk) disable iff (!rst_n)
        (limit_i == '0) |=> flt_o == $past(raw_i));
endmodule

// File: rtl/supply_fault_det.sv
module supply_fault_det
    import sfd_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick_i,
    input  logic [DW-1:0] level_i,
    input  logic          cfg_we_i,
    input  logic [AW-1:0] cfg_addr_i,
    input  logic [DW-1:0] cfg_wdata_i,
    output logic          fault_o
);
    cfg_t          cfg;
    logic          raw_fault;
    logic [CW-1:0] limit;

    sfd_regs u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (cfg_we_i),
        .addr_i  (cfg_addr_i),
        .wdata_i (cfg_wdata_i),
        .cfg_o   (cfg)
    );

    sfd_compare u_cmp (
        .clk     (clk),
        .rst_n   (rst_n),
        .level_i (level_i),
        .cfg_i   (cfg),
        .raw_o   (raw_fault)
    );

    assign limit = tsel_ticks(cfg.tsel);

    sfd_glitch u_flt (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_i  (tick_i),
        .raw_i   (raw_fault),
        .limit_i (limit),
        .flt_o   (fault_o)
    );
endmodule

// File: tb/supply_fault_det_tb_top.sv
`timescale 1ns/1ps
module supply_fault_det_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic [7:0] level = 8'd128;
    logic       we = 1'b0;
    logic [2:0] addr = '0;
    logic [7:0] wdata = '0;
    logic       fault;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    supply_fault_det dut_i (
        .clk(clk), .rst_n(rst_n), .tick_i(tick), .level_i(level),
        .cfg_we_i(we), .cfg_addr_i(addr), .cfg_wdata_i(wdata), .fault_o(fault)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: fault_o=%0b expected %0b (level=%0d)", req, act, exp, level);
        end
    endtask

    task automatic wclk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        addr = a; wdata = d; we = 1'b1;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic setlv(input int v);
        level = 8'(v);
        wclk(2);
    endtask

    task automatic pulse_tick;
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
    endtask

    function automatic int ticks_of(input int s);
        int t[8] = '{0, 1, 2, 3, 4, 6, 8, 10};
        return t[s];
    endfunction

    // arithmetic model of the two flags
    bit m_uv, m_ov;

    task automatic sweep(input int ft, input int uvt, input int uh,
                         input int ovt, input int oh);
        setlv(128);
        wr(3'd4, 8'(ft));
        wr(3'd1, 8'd0); wr(3'd3, 8'd0);
        wr(3'd0, 8'd0); wr(3'd2, 8'hFF);
        wclk(2);
        level = 8'(uvt);
        wclk(1);
        wr(3'd1, 8'(uh)); wr(3'd3, 8'(oh));
        wr(3'd0, 8'(uvt)); wr(3'd2, 8'(ovt));
        wclk(2);
        m_uv = 0; m_ov = 0;
        for (int k = 0; k < 512; k++) begin
            int lv;
            bit e;
            lv = (k < 256) ? 255 - k : k - 256;
            setlv(lv);
            if (!m_uv) m_uv = lv < uvt;
            else if (lv > uvt + uh) m_uv = 0;
            if (!m_ov) m_ov = lv > ovt;
            else if (lv + oh < ovt) m_ov = 0;
            e = (ft == 0) ? m_uv : (ft == 1) ? m_ov : (m_uv | m_ov);
            if (ft == 0)      chk("R2/R3 uv sweep", fault, e);
            else if (ft == 1) chk("R4/R5 ov sweep", fault, e);
            else              chk("R7 window sweep", fault, e);
        end
    endtask

    initial begin
        #(150000 * 5);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: run hung, got timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        level = 8'd0;
        wclk(3);
        rst_n = 1'b1;
        wclk(3);
        // R1: reset values
        chk("R1 reset fault low", fault, 1'b0);
        wr(3'd4, 8'd1);
        setlv(255);
        chk("R1 ov limit 0xFF", fault, 1'b0);
        wr(3'd4, 8'd0);
        wr(3'd0, 8'd100);
        setlv(99);  chk("R2 below uv limit", fault, 1'b1);
        setlv(100); chk("R1 zero hyst hold", fault, 1'b1);
        setlv(101); chk("R3 release above limit", fault, 1'b0);

        // R6: only low five hysteresis bits kept (0xE3 -> 3)
        wr(3'd1, 8'hE3);
        setlv(99);  chk("R6 enter", fault, 1'b1);
        setlv(103); chk("R6 masked hyst hold", fault, 1'b1);
        setlv(104); chk("R6 masked hyst release", fault, 1'b0);
        wr(3'd5, 8'h00); // unmapped address, no effect
        setlv(99);  chk("R6 unmapped write ignored", fault, 1'b1);
        setlv(150);

        // R7: fault kinds
        wr(3'd1, 8'd0); wr(3'd0, 8'd60); wr(3'd2, 8'd180);
        setlv(30);
        wr(3'd4, 8'd0); wclk(2); chk("R7 uv kind low level", fault, 1'b1);
        wr(3'd4, 8'd1); wclk(2); chk("R7 ov kind low level", fault, 1'b0);
        wr(3'd4, 8'd2); wclk(2); chk("R7 window kind 2 low level", fault, 1'b1);
        wr(3'd4, 8'd3); wclk(2); chk("R7 window kind 3 low level", fault, 1'b1);
        setlv(220);
        wr(3'd4, 8'd0); wclk(2); chk("R7 uv kind high level", fault, 1'b0);
        wr(3'd4, 8'd1); wclk(2); chk("R7 ov kind high level", fault, 1'b1);
        wr(3'd4, 8'd3); wclk(2); chk("R7 window kind 3 high level", fault, 1'b1);
        setlv(120);       chk("R7 window in band", fault, 1'b0);

        // R11: limit rewritten while a flag is set
        wr(3'd4, 8'd0); wr(3'd0, 8'd100); wr(3'd1, 8'd5);
        setlv(50);  chk("R11 uv set", fault, 1'b1);
        setlv(102); chk("R11 uv held in band", fault, 1'b1);
        wr(3'd0, 8'd90); wclk(2);
        chk("R11 uv released by new limit", fault, 1'b0);
        wr(3'd4, 8'd1); wr(3'd2, 8'd200); wr(3'd3, 8'd10);
        setlv(220); chk("R11 ov set", fault, 1'b1);
        setlv(195); chk("R11 ov held in band", fault, 1'b1);
        wr(3'd2, 8'd210); wclk(2);
        chk("R11 ov released by new limit", fault, 1'b0);

        // sweeps (R2 R3 R4 R5 R7)
        sweep(2, 60, 7, 180, 12);
        sweep(0, 128, 31, 255, 0);
        sweep(1, 0, 0, 100, 31);
        sweep(1, 0, 0, 10, 20);
        sweep(3, 20, 31, 20, 31);

        // R10: transparent latency
        wr(3'd4, 8'd0); wr(3'd1, 8'd0); wr(3'd0, 8'd100); wr(3'd2, 8'hFF);
        setlv(150);
        level = 8'd50;
        wclk(1); chk("R10 one edge not yet", fault, 1'b0);
        wclk(1); chk("R10 second edge", fault, 1'b1);
        setlv(150); chk("R10 release", fault, 1'b0);

        // R8 / R9: each timeout code
        for (int s = 1; s < 8; s++) begin
            int t;
            t = ticks_of(s);
            wr(3'd4, 8'(s << 2));
            setlv(50);
            for (int j = 1; j < t; j++) begin
                pulse_tick();
                chk("R9 short pulse suppressed", fault, 1'b0);
            end
            setlv(150);
            for (int j = 0; j <= t; j++) begin
                pulse_tick();
                chk("R9 no late output", fault, 1'b0);
            end
            setlv(50);
            wclk(3);
            chk("R8 no change without tick", fault, 1'b0);
            for (int j = 1; j <= t; j++) begin
                pulse_tick();
                chk("R8 rise after timeout", fault, (j >= t) ? 1'b1 : 1'b0);
            end
            setlv(150);
            for (int j = 1; j <= t; j++) begin
                pulse_tick();
                chk("R8 fall after timeout", fault, (j >= t) ? 1'b0 : 1'b1);
            end
        end

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule